// File: doc/BRIEF.md
# Luma Block-Aligned Noise Coring

This block removes small, noisy detail from a stream of 10-bit luma samples. A three-tap high-pass filter extracts the detail around each sample. When that detail is smaller in magnitude than a programmable threshold, it is treated as noise: a scaled copy of it is subtracted from the sample. Larger detail is treated as real picture content, and the sample passes through unchanged.

The scale factor depends on where the pixel sits in a horizontal grid of 8-pixel blocks. Pixels on the first or last column of a block get one gain. All other pixels get a second gain. This lets compression block edges be smoothed harder or softer than block interiors. A programmable offset shifts the grid one pixel at a time, so the grid can be aligned with the source's actual block boundaries. The line-start strobe reloads the position from the offset.

Samples enter with a valid strobe and a line-start flag. The processed sample leaves two clock cycles later with its own valid strobe. Configuration inputs are sampled in the same cycle as the sample they apply to.

Top module: `luma_block_coring`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly two clock cycles. An output sample belongs to the input sample accepted two cycles earlier.
- R2: The detail term is `hp = floor((2*x[n] - x[n-1] - x[n-2]) / 4)`, as a signed integer. Here x[n-1] and x[n-2] are the two previous valid samples. Cycles with `in_valid` low do not advance this history.
- R3: A valid sample with `in_line_start` high uses itself in place of both previous samples, so its `hp` is 0. Such a sample is therefore output unchanged.
- R4: A sample is cored only when `|hp| < cfg_threshold`. Otherwise it is output unchanged. A threshold of 0 disables coring.
- R5: A cored sample becomes `x - floor(g*hp/8)`. Here g is a 4-bit unsigned gain in eighths (0 to 15/8). With both gains at 0, every sample passes unchanged.
- R6: Pixel position runs modulo 8. It is set to `cfg_offset` on a valid line-start sample and rises by one on each further valid sample. Positions 0 and 7 use `cfg_gain_border`; positions 1 to 6 use `cfg_gain_inner`.
- R7: The result is clamped to the range 0 to 1023.
- R8: `out_luma` holds its last value while `out_valid` is low.
- R9: While `rst` is high, `out_valid` and `out_luma` are 0, and the position counter and filter history are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_line_start | input | 1 | Marks the first valid sample of a line |
| in_luma | input | 10 | Input luma sample |
| cfg_threshold | input | 10 | Coring threshold on the detail magnitude |
| cfg_gain_border | input | 4 | Gain in eighths for block-border pixels |
| cfg_gain_inner | input | 4 | Gain in eighths for block-interior pixels |
| cfg_offset | input | 3 | Grid position given to a line-start pixel |
| out_valid | output | 1 | Output sample strobe |
| out_luma | output | 10 | Processed luma sample |

## Verification
A wrong filter history or a wrong position counter shows up in `out_luma` two cycles after the first affected valid sample. With border and inner gains set far apart, an off-by-one grid position produces a visibly different result within a single block. Holding invalid cycles between valid ones exposes any history that advances when it should not. An error in the clamp or in the rounding of the scaled detail appears only for particular sample triplets, so the stimulus sweeps gains, thresholds and offsets against an arithmetic model of the same formulas.

// File: rtl/lnc_pkg.sv
package lnc_pkg;

    localparam int LNC_DATA_W    = 10;
    localparam int LNC_BLK_W     = 8;
    localparam int LNC_GAIN_W    = 4;
    localparam int LNC_GAIN_FRAC = 3;

    typedef enum logic {
        PIX_INNER  = 1'b0,
        PIX_BORDER = 1'b1
    } pix_class_e;

    // first and last column of a block are treated as its border
    function automatic logic is_edge_pos(int unsigned pos, int unsigned blk_w);
        return (pos == 0) || (pos == blk_w - 1);
    endfunction

endpackage

// File: rtl/lnc_hpf.sv
module lnc_hpf #(
    parameter int DATA_W = 10,
    parameter int HP_W   = DATA_W + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic                   in_line_start,
    input  logic [DATA_W-1:0]      in_luma,
    output logic signed [HP_W-1:0] hp
);
    localparam int D_W = DATA_W + 2;

    logic [DATA_W-1:0]     hist1_q, hist2_q;
    logic [DATA_W-1:0]     prev1, prev2;
    logic signed [D_W-1:0] xs, p1s, p2s, diff, shifted;

    // a line start sees a flat neighbourhood made of itself
    always_comb begin
        prev1   = in_line_start ? in_luma : hist1_q;
        prev2   = in_line_start ? in_luma : hist2_q;
        xs      = $signed({2'b00, in_luma});
        p1s     = $signed({2'b00, prev1});
        p2s     = $signed({2'b00, prev2});
        diff    = (xs <<< 1) - p1s - p2s;
        shifted = diff >>> 2;
        hp      = shifted[HP_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist1_q <= '0;
            hist2_q <= '0;
        end else if (in_valid) begin
            hist1_q <= in_luma;
            hist2_q <= prev1;
        end
    end

endmodule

// File: rtl/lnc_grid.sv
module lnc_grid
    import lnc_pkg::*;
#(
    parameter int BLK_W = 8,
    parameter int OFS_W = $clog2(BLK_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_line_start,
    input  logic [OFS_W-1:0] cfg_offset,
    output pix_class_e       pix_class
);
    localparam logic [OFS_W-1:0] LAST_POS = OFS_W'(BLK_W - 1);

    logic [OFS_W-1:0] cnt_q, pos, pos_next;

    always_comb begin
        pos       = in_line_start ? cfg_offset : cnt_q;
        pos_next  = (pos == LAST_POS) ? '0 : pos + 1'b1;
        pix_class = is_edge_pos(int'(unsigned'(pos)), BLK_W) ? PIX_BORDER : PIX_INNER;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (in_valid) begin
            cnt_q <= pos_next;
        end
    end

endmodule

// File: rtl/lnc_core.sv
module lnc_core #(
    parameter int DATA_W    = 10,
    parameter int HP_W      = DATA_W + 1,
    parameter int GAIN_W    = 4,
    parameter int GAIN_FRAC = 3
) (
    input  logic [DATA_W-1:0]      luma,
    input  logic signed [HP_W-1:0] hp,
    input  logic [GAIN_W-1:0]      gain,
    input  logic                   core_en,
    output logic [DATA_W-1:0]      result
);
    localparam int P_W = HP_W + GAIN_W + 2;
    localparam logic signed [P_W-1:0] MAXV = P_W'((1 << DATA_W) - 1);

    logic signed [P_W-1:0] gs, hs, prod, scaled, xs, diff;

    always_comb begin
        gs     = $signed({{(P_W-GAIN_W){1'b0}}, gain});
        hs     = {{(P_W-HP_W){hp[HP_W-1]}}, hp};
        xs     = $signed({{(P_W-DATA_W){1'b0}}, luma});
        prod   = gs * hs;
        scaled = prod >>> GAIN_FRAC;
        diff   = xs - scaled;
        if (!core_en) begin
            result = luma;
        end else if (diff < 0) begin
            result = '0;
        end else if (diff > MAXV) begin
            result = MAXV[DATA_W-1:0];
        end else begin
            result = diff[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/luma_block_coring.sv
module luma_block_coring
    import lnc_pkg::*;
#(
    parameter int DATA_W    = LNC_DATA_W,
    parameter int BLK_W     = LNC_BLK_W,
    parameter int GAIN_W    = LNC_GAIN_W,
    parameter int GAIN_FRAC = LNC_GAIN_FRAC,
    parameter int OFS_W     = $clog2(BLK_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_line_start,
    input  logic [DATA_W-1:0] in_luma,
    input  logic [DATA_W-1:0] cfg_threshold,
    input  logic [GAIN_W-1:0] cfg_gain_border,
    input  logic [GAIN_W-1:0] cfg_gain_inner,
    input  logic [OFS_W-1:0]  cfg_offset,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_luma
);
    localparam int HP_W = DATA_W + 1;

    typedef struct packed {
        logic                   valid;
        logic [DATA_W-1:0]      luma;
        logic signed [HP_W-1:0] hp;
        logic [GAIN_W-1:0]      gain;
        logic                   core_en;
    } stage_t;

    logic signed [HP_W-1:0] hp_c;
    logic [HP_W-1:0]        mag_c;
    pix_class_e             cls_c;
    stage_t                 s1_d, s1_q;
    logic [DATA_W-1:0]      cored_c;

    lnc_hpf #(.DATA_W(DATA_W), .HP_W(HP_W)) u_hpf (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_line_start (in_line_start),
        .in_luma       (in_luma),
        .hp            (hp_c)
    );

    lnc_grid #(.BLK_W(BLK_W), .OFS_W(OFS_W)) u_grid (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_line_start (in_line_start),
        .cfg_offset    (cfg_offset),
        .pix_class     (cls_c)
    );

    always_comb begin
        mag_c        = hp_c[HP_W-1] ? HP_W'(-hp_c) : HP_W'(hp_c);
        s1_d.valid   = in_valid;
        s1_d.luma    = in_luma;
        s1_d.hp      = hp_c;
        s1_d.gain    = (cls_c == PIX_BORDER) ? cfg_gain_border : cfg_gain_inner;
        s1_d.core_en = mag_c < {1'b0, cfg_threshold};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q <= s1_d;
        end
    end

    lnc_core #(
        .DATA_W    (DATA_W),
        .HP_W      (HP_W),
        .GAIN_W    (GAIN_W),
        .GAIN_FRAC (GAIN_FRAC)
    ) u_core (
        .luma    (s1_q.luma),
        .hp      (s1_q.hp),
        .gain    (s1_q.gain),
        .core_en (s1_q.core_en),
        .result  (cored_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_luma  <= '0;
        end else begin
            out_valid <= s1_q.valid;
            if (s1_q.valid) begin
                out_luma <= cored_c;
            end
        end
    end

endmodule

// File: rtl/lnc_checker.sv
module lnc_checker #(
    parameter int DATA_W = 10,
    parameter int GAIN_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_line_start,
    input logic [DATA_W-1:0] in_luma,
    input logic [DATA_W-1:0] cfg_threshold,
    input logic [GAIN_W-1:0] cfg_gain_border,
    input logic [GAIN_W-1:0] cfg_gain_inner,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_luma
);
    logic [1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2) |-> (out_valid == $past(in_valid, 2))); // R1

    AST_LINE_START_FLAT: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2 && $past(in_valid && in_line_start, 2))
        |-> (out_luma == $past(in_luma, 2))); // R3

    AST_ZERO_THRESHOLD_PASS: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2 && $past(in_valid, 2) && $past(cfg_threshold, 2) == '0)
        |-> (out_luma == $past(in_luma, 2))); // R4

    AST_ZERO_GAIN_PASS: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2 && $past(in_valid, 2) && $past(cfg_gain_border, 2) == '0
         && $past(cfg_gain_inner, 2) == '0)
        |-> (out_luma == $past(in_luma, 2))); // R5

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd1 && !out_valid) |-> $stable(out_luma)); // R8

endmodule

bind luma_block_coring lnc_checker #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_lnc_checker (
    .clk             (clk),
    .rst             (rst),
    .in_valid        (in_valid),
    .in_line_start   (in_line_start),
    .in_luma         (in_luma),
    .cfg_threshold   (cfg_threshold),
    .cfg_gain_border (cfg_gain_border),
    .cfg_gain_inner  (cfg_gain_inner),
    .out_valid       (out_valid),
    .out_luma        (out_luma)
);

// File: tb/luma_block_coring_bench.sv
module luma_block_coring_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_line_start = 1'b0;
    logic [9:0] in_luma = '0;
    logic [9:0] cfg_threshold = '0;
    logic [3:0] cfg_gain_border = '0;
    logic [3:0] cfg_gain_inner = '0;
    logic [2:0] cfg_offset = '0;
    logic       out_valid;
    logic [9:0] out_luma;

    always #4 clk = ~clk;

    luma_block_coring u_luma_block_coring (
        .clk             (clk),
        .rst             (rst),
        .in_valid        (in_valid),
        .in_line_start   (in_line_start),
        .in_luma         (in_luma),
        .cfg_threshold   (cfg_threshold),
        .cfg_gain_border (cfg_gain_border),
        .cfg_gain_inner  (cfg_gain_inner),
        .cfg_offset      (cfg_offset),
        .out_valid       (out_valid),
        .out_luma        (out_luma)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 0;

    // arithmetic model state
    int    m_h1, m_h2, m_cnt, m_last;
    bit    p_v0, p_v1;
    int    p_y0, p_y1;
    string p_t0, p_t1;

    task automatic check(input string req, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_h1 = 0; m_h2 = 0; m_cnt = 0; m_last = 0;
        p_v0 = 0; p_v1 = 0; p_y0 = 0; p_y1 = 0;
        p_t0 = "R1"; p_t1 = "R1";
    endtask

    task automatic model_px(input bit ls, input int x, output int y);
        int a, b, d, hp, mag, pos, g, q;
        a   = ls ? x : m_h1;
        b   = ls ? x : m_h2;
        d   = 2 * x - a - b;
        hp  = d >>> 2;                                  // R2 floor division
        mag = (hp < 0) ? -hp : hp;
        pos = ls ? int'(cfg_offset) : m_cnt;            // R6
        m_cnt = (pos + 1) % 8;
        g   = (pos == 0 || pos == 7) ? int'(cfg_gain_border) : int'(cfg_gain_inner);
        m_h2 = a;
        m_h1 = x;
        if (mag < int'(cfg_threshold)) begin            // R4
            q = (g * hp) >>> 3;                         // R5
            y = x - q;
            if (y < 0) y = 0;                           // R7
            if (y > 1023) y = 1023;
        end else begin
            y = x;
        end
    endtask

    task automatic step(input bit v, input bit ls, input int x, input string tag);
        int ey;
        check("R1", int'(out_valid), int'(p_v1), "out_valid");
        if (p_v1) begin
            check(p_t1, int'(out_luma), p_y1, "out_luma");
            m_last = p_y1;
        end else begin
            check("R8", int'(out_luma), m_last, "held out_luma");
        end
        in_valid      = v;
        in_line_start = ls;
        in_luma       = 10'(x);
        ey = 0;
        if (v) model_px(ls, x, ey);
        p_v1 = p_v0; p_y1 = p_y0; p_t1 = p_t0;
        p_v0 = v;    p_y0 = ey;   p_t0 = tag;
        @(negedge clk);
    endtask

    function automatic int clip(input int v);
        return (v < 0) ? 0 : ((v > 1023) ? 1023 : v);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R9", int'(out_valid), 0, "reset out_valid");
        check("R9", int'(out_luma), 0, "reset out_luma");
        rst = 1'b0;

        // R3: line-start samples pass unchanged even at full coring
        cfg_threshold = 10'd1023; cfg_gain_border = 4'd15; cfg_gain_inner = 4'd15; cfg_offset = 3'd0;
        for (int ln = 0; ln < 12; ln++) begin
            step(1, 1, int'($urandom_range(0, 1023)), "R3");
            for (int k = 0; k < 3; k++) step(1, 0, int'($urandom_range(0, 1023)), "R2");
        end

        // R2: valid gaps must not advance history; idle cycles hold output
        cfg_gain_border = 4'd8; cfg_gain_inner = 4'd5; cfg_offset = 3'd2;
        for (int i = 0; i < 400; i++) begin
            bit v  = ($urandom_range(0, 9) < 7);
            bit ls = v && ($urandom_range(0, 19) == 0);
            step(v, ls, int'($urandom_range(0, 1023)), "R2");
        end

        // R4: threshold sweep on small-detail data
        foreach (cfg_threshold[i]) ;
        for (int t = 0; t < 6; t++) begin
            int base;
            cfg_threshold = (t == 0) ? 10'd0 : 10'(1 << (2 * t - 2));
            cfg_gain_border = 4'd12; cfg_gain_inner = 4'd12;
            base = int'($urandom_range(100, 900));
            step(1, 1, base, "R4");
            for (int i = 0; i < 80; i++)
                step(1, 0, clip(base + int'($urandom_range(0, 80)) - 40), "R4");
        end

        // R5: every gain value
        cfg_threshold = 10'd1023;
        for (int g = 0; g < 16; g++) begin
            cfg_gain_border = 4'(g); cfg_gain_inner = 4'(g);
            step(1, 1, int'($urandom_range(0, 1023)), "R5");
            for (int i = 0; i < 40; i++) step(1, 0, int'($urandom_range(0, 1023)), "R5");
        end

        // R6: grid offsets with border and inner gains far apart
        cfg_gain_border = 4'd15; cfg_gain_inner = 4'd0;
        for (int o = 0; o < 8; o++) begin
            cfg_offset = 3'(o);
            step(1, 1, 500, "R6");
            for (int i = 1; i < 19; i++) step(1, 0, (i % 2) ? 530 : 470 + 2 * i, "R6");
        end

        // R7: upper clamp reached
        cfg_offset = 3'd0; cfg_gain_border = 4'd15; cfg_gain_inner = 4'd15;
        for (int r = 0; r < 4; r++) begin
            step(1, 1, 1023, "R7");
            step(1, 0, 1023, "R7");
            step(1, 0, 1020 - r, "R7");
            step(0, 0, 7, "R8");
        end

        for (int i = 0; i < 4; i++) step(0, 0, int'($urandom_range(0, 1023)), "R8");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule